// File: doc/BRIEF.md
# Retention Latch Result Cache

A small fully associative store that sits beside a reorder buffer whose source-operand read ports have been removed. Each freshly computed result is written into the store together with the reorder-buffer slot number that produced it. Dispatch logic that needs a value still in flight probes the store by slot number and gets a hit flag and the value one clock later. A miss tells the dispatch stage to fall back to forwarding at commit time.

Up to `WR_PORTS` results are inserted per cycle and up to `RD_PORTS` probes run per cycle. Replacement is first-in first-out by default. A least-recently-used mode is also available, in which a probe hit renews an entry. In that mode a committing slot number also removes its entry, so a reused slot number never finds a stale value. A mispredict flush empties the whole store in one cycle.

Top module: `retention_cache`

## Requirements
- R1: After synchronous reset every entry is empty and every `rd_hit` and `rd_data` output is 0.
- R2: A probe presented with `rd_valid` high produces `rd_hit`/`rd_data` on the next cycle. The hit flag is set when a valid entry holds the probed slot number, and the data is that entry's value. A miss, or a port with `rd_valid` low, returns hit 0 and data 0.
- R3: Every asserted write port installs its slot number and value in the same cycle, so up to `WR_PORTS` results enter per cycle.
- R4: A probe issued in the same cycle as the write of that slot number reports a miss. The same probe one cycle later hits.
- R5: With `lru_mode` = 0, entries are replaced in ring order from position 0 after reset or flush. The writes of one cycle take consecutive positions, lower port index first, whatever the contents.
- R6: With `lru_mode` = 0, `commit_valid` has no effect on the contents.
- R7: With `lru_mode` = 1, each write takes the lowest-index empty entry not already chosen this cycle. When none is left it takes the entry used least recently. Use means the last write or probe hit, and ties go to the lower index.
- R8: With `lru_mode` = 1, a probe hit marks its entry as just used. A probe hit in FIFO mode changes nothing.
- R9: With `lru_mode` = 1, `commit_valid` removes the entry holding `commit_key`, visible to probes issued from the next cycle on.
- R10: `flush` empties every entry and rewinds the ring position in one cycle, and writes in the flush cycle are discarded. Probes issued in the flush cycle still see the contents from before the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lru_mode | input | 1 | 0 = ring (FIFO) replacement, 1 = least-recently-used replacement |
| flush | input | 1 | Mispredict: empty the whole store |
| commit_valid | input | 1 | A slot number is committing |
| commit_key | input | KEY_W | Committing slot number |
| wr_valid | input | WR_PORTS | Per-port write enable |
| wr_key | input | WR_PORTS x KEY_W | Slot number per write port |
| wr_data | input | WR_PORTS x DATA_W | Result value per write port |
| rd_valid | input | RD_PORTS | Per-port probe enable |
| rd_key | input | RD_PORTS x KEY_W | Slot number per probe port |
| rd_hit | output | RD_PORTS | Registered hit flag per probe port |
| rd_data | output | RD_PORTS x DATA_W | Registered value per probe port, 0 on miss |

## Verification
The assertions assume that no two live entries ever hold the same slot number. This holds because writers never insert a slot number still held and not yet committed, and because `lru_mode` changes only in a cycle that also flushes. The stimulus models a reorder-buffer ring of 128 slot numbers with at most 100 in flight. A slot number is written only once the commit pointer has passed its previous use, and every mode change is paired with a flush. Probes draw from the twelve most recently issued slot numbers, which gives a useful mix of hits and misses in both modes.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  typedef enum logic {
    POL_FIFO = 1'b0,
    POL_LRU  = 1'b1
  } repl_pol_e;
endpackage

// File: rtl/rlc_match.sv
module rlc_match #(
  parameter int N      = 8,
  parameter int KEY_W  = 7,
  parameter int DATA_W = 32
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0][KEY_W-1:0]  key_tab,
  input  logic [N-1:0][DATA_W-1:0] data_tab,
  input  logic [KEY_W-1:0]         probe,
  output logic [N-1:0]             match,
  output logic                     hit,
  output logic [DATA_W-1:0]        value
);
  always_comb begin
    value = '0;
    for (int i = 0; i < N; i++) begin
      match[i] = valid[i] && (key_tab[i] == probe);
      if (match[i]) value = value | data_tab[i];
    end
    hit = |match;
  end
endmodule

// File: rtl/rlc_victim.sv
module rlc_victim
  import rlc_pkg::*;
#(
  parameter int N        = 8,
  parameter int WR_PORTS = 2,
  parameter int STAMP_W  = 32,
  localparam int IDX_W   = $clog2(N)
) (
  input  repl_pol_e                  pol,
  input  logic [N-1:0]               valid,
  input  logic [N-1:0][STAMP_W-1:0]  stamp,
  input  logic [IDX_W-1:0]           wptr,
  input  logic [WR_PORTS-1:0]        wr_valid,
  output logic [WR_PORTS-1:0][IDX_W-1:0] slot,
  output logic [IDX_W-1:0]           ptr_next
);
  logic [N-1:0]       taken;
  logic               found;
  logic [STAMP_W-1:0] best;
  logic [IDX_W-1:0]   pick;
  int                 cnt;

  always_comb begin
    taken = '0;
    cnt   = 0;
    found = 1'b0;
    best  = '0;
    pick  = '0;
    for (int p = 0; p < WR_PORTS; p++) begin
      slot[p] = '0;
      if (wr_valid[p]) begin
        pick = '0;
        if (pol == POL_FIFO) begin
          pick = IDX_W'((int'(wptr) + cnt) % N);
        end else begin
          found = 1'b0;
          for (int i = 0; i < N; i++) begin
            if (!found && !valid[i] && !taken[i]) begin
              pick  = IDX_W'(i);
              found = 1'b1;
            end
          end
          if (!found) begin
            best = '0;
            for (int i = 0; i < N; i++) begin
              if (!taken[i] && (!found || stamp[i] < best)) begin
                best  = stamp[i];
                pick  = IDX_W'(i);
                found = 1'b1;
              end
            end
          end
        end
        slot[p]     = pick;
        taken[pick] = 1'b1;
        cnt         = cnt + 1;
      end
    end
    ptr_next = IDX_W'((int'(wptr) + cnt) % N);
  end
endmodule

// File: rtl/retention_cache.sv
module retention_cache
  import rlc_pkg::*;
#(
  parameter int N        = 8,
  parameter int KEY_W    = 7,
  parameter int DATA_W   = 32,
  parameter int WR_PORTS = 2,
  parameter int RD_PORTS = 2,
  parameter int STAMP_W  = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             lru_mode,
  input  logic                             flush,
  input  logic                             commit_valid,
  input  logic [KEY_W-1:0]                 commit_key,
  input  logic [WR_PORTS-1:0]              wr_valid,
  input  logic [WR_PORTS-1:0][KEY_W-1:0]   wr_key,
  input  logic [WR_PORTS-1:0][DATA_W-1:0]  wr_data,
  input  logic [RD_PORTS-1:0]              rd_valid,
  input  logic [RD_PORTS-1:0][KEY_W-1:0]   rd_key,
  output logic [RD_PORTS-1:0]              rd_hit,
  output logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data
);
  localparam int IDX_W = $clog2(N);

  repl_pol_e                   pol;
  logic [N-1:0]                valid_q;
  logic [N-1:0][KEY_W-1:0]     key_q;
  logic [N-1:0][DATA_W-1:0]    data_q;
  logic [N-1:0][STAMP_W-1:0]   stamp_q;
  logic [IDX_W-1:0]            wptr_q;
  logic [STAMP_W-1:0]          tick_q;

  logic [N-1:0]                rmatch [RD_PORTS];
  logic [RD_PORTS-1:0]         rhit;
  logic [DATA_W-1:0]           rval   [RD_PORTS];
  logic [N-1:0]                cmatch;
  logic [WR_PORTS-1:0][IDX_W-1:0] slot;
  logic [IDX_W-1:0]            ptr_next;

  assign pol = repl_pol_e'(lru_mode);

  // Associative probe, one comparator bank per read port
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_probe
    rlc_match #(.N(N), .KEY_W(KEY_W), .DATA_W(DATA_W)) i_match (
      .valid   (valid_q),
      .key_tab (key_q),
      .data_tab(data_q),
      .probe   (rd_key[p]),
      .match   (rmatch[p]),
      .hit     (rhit[p]),
      .value   (rval[p])
    );
  end

  // Commit comparator bank
  always_comb begin
    for (int i = 0; i < N; i++)
      cmatch[i] = valid_q[i] && (key_q[i] == commit_key);
  end

  rlc_victim #(.N(N), .WR_PORTS(WR_PORTS), .STAMP_W(STAMP_W)) i_victim (
    .pol     (pol),
    .valid   (valid_q),
    .stamp   (stamp_q),
    .wptr    (wptr_q),
    .wr_valid(wr_valid),
    .slot    (slot),
    .ptr_next(ptr_next)
  );

  // Valid bits, ring pointer and use clock
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      wptr_q  <= '0;
      tick_q  <= '0;
    end else begin
      tick_q <= tick_q + 1'b1;
      if (flush) begin
        valid_q <= '0;
        wptr_q  <= '0;
      end else begin
        if (pol == POL_LRU && commit_valid) valid_q <= valid_q & ~cmatch;
        for (int p = 0; p < WR_PORTS; p++)
          if (wr_valid[p]) valid_q[slot[p]] <= 1'b1;
        wptr_q <= ptr_next;
      end
    end
  end

  // Entry payload: keys, values and last-use stamps (no reset needed)
  always_ff @(posedge clk) begin
    for (int p = 0; p < RD_PORTS; p++)
      if (!flush && pol == POL_LRU && rd_valid[p] && rhit[p])
        for (int i = 0; i < N; i++)
          if (rmatch[p][i]) stamp_q[i] <= tick_q;
    for (int p = 0; p < WR_PORTS; p++) begin
      if (wr_valid[p]) begin
        key_q[slot[p]]   <= wr_key[p];
        data_q[slot[p]]  <= wr_data[p];
        stamp_q[slot[p]] <= tick_q;
      end
    end
  end

  // Registered probe results
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hit  <= '0;
      rd_data <= '0;
    end else begin
      for (int p = 0; p < RD_PORTS; p++) begin
        rd_hit[p]  <= rd_valid[p] && rhit[p];
        rd_data[p] <= (rd_valid[p] && rhit[p]) ? rval[p] : '0;
      end
    end
  end

  // R2
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_chk
    hit_needs_probe_chk: assert property (@(posedge clk) disable iff (rst)
      rd_hit[p] |-> $past(rd_valid[p]));
    // R2
    key_unique_chk: assert property (@(posedge clk) disable iff (rst)
      rd_valid[p] |-> $onehot0(rmatch[p]));
  end

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0));

  // R6
  fifo_no_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    (pol == POL_FIFO && !flush) |=> ($countones(valid_q) >= $countones($past(valid_q))));

  // R7
  lru_free_first_chk: assert property (@(posedge clk) disable iff (rst)
    (pol == POL_LRU && !flush && !commit_valid &&
     (N - $countones(valid_q)) >= $countones(wr_valid))
    |=> ($countones(valid_q) == $countones($past(valid_q)) + $countones($past(wr_valid))));
endmodule

// File: tb/test_retention_cache.sv
module test_retention_cache;
  localparam int N = 8, KW = 7, DW = 32, W = 2, L = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lru_mode, flush, commit_valid;
  logic [KW-1:0] commit_key;
  logic [W-1:0] wr_valid;
  logic [W-1:0][KW-1:0] wr_key;
  logic [W-1:0][DW-1:0] wr_data;
  logic [L-1:0] rd_valid;
  logic [L-1:0][KW-1:0] rd_key;
  logic [L-1:0] rd_hit;
  logic [L-1:0][DW-1:0] rd_data;

  always #2 clk = ~clk;

  retention_cache #(.N(N), .KEY_W(KW), .DATA_W(DW), .WR_PORTS(W), .RD_PORTS(L)) i_retention_cache (
    .clk(clk), .rst(rst), .lru_mode(lru_mode), .flush(flush),
    .commit_valid(commit_valid), .commit_key(commit_key),
    .wr_valid(wr_valid), .wr_key(wr_key), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_key(rd_key), .rd_hit(rd_hit), .rd_data(rd_data));

  int total = 0, fails = 0;

  // Reference model state
  bit          m_valid [N];
  int          m_key   [N];
  logic [31:0] m_data  [N];
  int          m_stamp [N];
  int          m_ptr = 0, m_tick = 0;
  bit          e_hit   [L];
  logic [31:0] e_data  [L];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic predict();
    for (int p = 0; p < L; p++) begin
      e_hit[p] = 0; e_data[p] = '0;
      if (rd_valid[p])
        for (int i = 0; i < N; i++)
          if (m_valid[i] && m_key[i] == int'(rd_key[p])) begin
            e_hit[p] = 1; e_data[p] = m_data[i];
          end
    end
  endtask

  task automatic model_update();
    int  vs [W];
    bit  taken [N];
    int  cnt, pick, best;
    bit  found;
    if (flush) begin
      for (int i = 0; i < N; i++) m_valid[i] = 0;
      m_ptr = 0;
    end else begin
      cnt = 0;
      for (int i = 0; i < N; i++) taken[i] = 0;
      for (int p = 0; p < W; p++) begin
        vs[p] = 0;
        if (wr_valid[p]) begin
          pick = 0;
          if (!lru_mode) pick = (m_ptr + cnt) % N;
          else begin
            found = 0;
            for (int i = 0; i < N; i++)
              if (!found && !m_valid[i] && !taken[i]) begin pick = i; found = 1; end
            if (!found) begin
              best = 0;
              for (int i = 0; i < N; i++)
                if (!taken[i] && (!found || m_stamp[i] < best)) begin
                  best = m_stamp[i]; pick = i; found = 1;
                end
            end
          end
          vs[p] = pick; taken[pick] = 1; cnt++;
        end
      end
      if (lru_mode)
        for (int p = 0; p < L; p++)
          if (rd_valid[p])
            for (int i = 0; i < N; i++)
              if (m_valid[i] && m_key[i] == int'(rd_key[p])) m_stamp[i] = m_tick;
      if (lru_mode && commit_valid)
        for (int i = 0; i < N; i++)
          if (m_valid[i] && m_key[i] == int'(commit_key)) m_valid[i] = 0;
      for (int p = 0; p < W; p++)
        if (wr_valid[p]) begin
          m_valid[vs[p]] = 1; m_key[vs[p]] = int'(wr_key[p]);
          m_data[vs[p]] = wr_data[p]; m_stamp[vs[p]] = m_tick;
        end
      m_ptr = (m_ptr + cnt) % N;
    end
    m_tick++;
  endtask

  task automatic clear_in();
    flush = 0; commit_valid = 0; commit_key = '0;
    wr_valid = '0; wr_key = '0; wr_data = '0; rd_valid = '0; rd_key = '0;
  endtask

  task automatic cyc(input string tag);
    predict();
    @(posedge clk); #1;
    for (int p = 0; p < L; p++) begin
      chk(rd_hit[p] == e_hit[p], tag, "hit", 32'(rd_hit[p]), 32'(e_hit[p]));
      chk(rd_data[p] == e_data[p], tag, "data", rd_data[p], e_data[p]);
    end
    model_update();
    clear_in();
  endtask

  task automatic wr(input int p, input int k);
    wr_valid[p] = 1; wr_key[p] = KW'(k); wr_data[p] = 32'hA000_0000 + 32'(k);
  endtask

  task automatic rd(input int p, input int k);
    rd_valid[p] = 1; rd_key[p] = KW'(k);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int next_key, cptr, nw;
    void'($urandom(32'd4242));
    lru_mode = 0; clear_in();
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_stamp[i] = 0; m_key[i] = 0; m_data[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset outputs
    chk(rd_hit == '0, "R1", "hit after reset", 32'(rd_hit), 0);
    chk(rd_data == '0, "R1", "data after reset", rd_data[0] | rd_data[1], 0);
    rd(0, 0); rd(1, 1); cyc("R1");
    // FIFO mode
    wr(0, 10); wr(1, 11); rd(0, 10); rd(1, 11); cyc("R4");
    rd(0, 10); rd(1, 11); cyc("R3 R4");
    wr(0, 12); wr(1, 13); cyc("R3");
    wr(0, 14); wr(1, 15); rd(0, 12); rd(1, 13); cyc("R3 R2");
    wr(0, 16); wr(1, 17); cyc("R3");
    wr(0, 18); commit_valid = 1; commit_key = 7'd11; cyc("R5");
    rd(0, 10); rd(1, 11); cyc("R5 R6");
    wr(1, 19); rd(0, 18); cyc("R5");
    rd(0, 11); rd(1, 12); cyc("R5");
    // R10: flush, probe sees old contents, same-cycle write dropped
    flush = 1; lru_mode = 1; wr(0, 30); rd(0, 12); rd(1, 19); cyc("R10");
    rd(0, 12); rd(1, 30); cyc("R10");
    // LRU mode
    wr(0, 20); wr(1, 21); cyc("R7");
    wr(0, 22); wr(1, 23); cyc("R7");
    wr(0, 24); wr(1, 25); cyc("R7");
    wr(0, 26); wr(1, 27); cyc("R7");
    rd(0, 20); cyc("R8");
    wr(0, 28); cyc("R7");
    rd(0, 20); rd(1, 21); cyc("R8");
    commit_valid = 1; commit_key = 7'd22; rd(0, 22); cyc("R9");
    rd(0, 22); rd(1, 23); cyc("R9");
    wr(0, 29); cyc("R7");
    rd(0, 23); rd(1, 29); cyc("R7");
    flush = 1; lru_mode = 0; cyc("R10");
    // Random traffic, both modes
    next_key = 0; cptr = 0;
    for (int c = 0; c < 4000; c++) begin
      if (c % 500 == 499) begin flush = 1; lru_mode = ~lru_mode; end
      else if ($urandom % 60 == 0) flush = 1;
      if (cptr != next_key && ($urandom % 2) == 1) begin
        commit_valid = 1; commit_key = KW'(cptr); cptr = (cptr + 1) % 128;
      end
      nw = $urandom % (W + 1);
      for (int p = 0; p < W; p++)
        if (p < nw && ((next_key - cptr + 128) % 128) < 100 && (p == 0 || ($urandom % 2) == 1)) begin
          wr_valid[p] = 1; wr_key[p] = KW'(next_key); wr_data[p] = $urandom;
          next_key = (next_key + 1) % 128;
        end
      for (int p = 0; p < L; p++)
        if (($urandom % 4) != 0) rd(p, (next_key + 127 - int'($urandom % 12)) % 128);
      cyc(lru_mode ? "R7 R8 R9" : "R2 R5 R6");
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule